// File: doc/BRIEF.md
# Thread and Warp ID CSR Unit

This block is the read side of the control/status register space for one core of a processor that has several cores, each running several warps of several threads. A read presents a register address with the index of the thread within its warp, the index of the warp within the core, and the core number. The block returns a 32-bit value on the same cycle. Identity registers give the thread or warp number at three levels: within the warp, within the core, and across the whole processor. They are computed from the indices and the size parameters on every access. Constant registers report the core number, the thread count per warp, the warp count per core and the core count.

Two 64-bit counters also run inside the block. One counts clock cycles and the other counts retired instructions. Each counter is read as a low word and a high word at separate addresses. Every other address falls through to a small generic register file with one synchronous write port. That file is indexed by the low address bits. The read port is a combinational lookup with no handshake: the value is valid whenever the inputs are stable, and a caller cannot stall it. The write port and the retire pulse are plain single-cycle strobes.

Top module: `csr_id_unit`

## Requirements
- R1: Address 0xCC0 returns `rd_tid`, zero-extended.
- R2: Address 0xCC1 returns `rd_tid + rd_wid*NUM_THREADS`.
- R3: Address 0xCC2 returns the value of R2 plus `NUM_THREADS*NUM_WARPS*core_id`.
- R4: Address 0xCC3 returns `rd_wid`. Address 0xCC4 returns `rd_wid + NUM_WARPS*core_id`.
- R5: Address 0xCC5 returns `core_id`. Address 0xFC0 returns NUM_THREADS, 0xFC1 returns NUM_WARPS and 0xFC2 returns NUM_CORES.
- R6: The cycle counter holds CTR_RST during reset and adds one on every clock edge after reset. Address 0xC00 returns its bits 31:0 and 0xC80 returns its bits 63:32.
- R7: The retire counter holds CTR_RST during reset and adds one on every clock edge where `retire` is high. Address 0xC02 returns its bits 31:0 and 0xC82 returns its bits 63:32.
- R8: Any other address reads the generic register selected by address bits 3:0. A write with `wr_en` high updates that register at the next clock edge. All generic registers read zero after reset.
- R9: Writes to the thirteen addresses listed in R1 to R7 are ignored. They change neither the value read at that address nor the generic register that shares its low address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_id | input | CID_W | Number of this core |
| retire | input | 1 | One instruction retired this cycle |
| rd_addr | input | 12 | Read address |
| rd_tid | input | TID_W | Thread index within the warp |
| rd_wid | input | WID_W | Warp index within the core |
| rd_data | output | XLEN | Read value, combinational |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write address |
| wr_data | input | XLEN | Write value |

## Verification
A corrupted counter shows up at the next read of its low or high address. The value then differs from a count that the bench keeps independently. The carry into the high word is exercised by starting both counters a little below a 32-bit boundary. A generic register that took a write it should have ignored, or that missed a write, is exposed by the first read of its index. Mistakes in the identity arithmetic need no state and appear in the same cycle as the read. Random sweeps of the thread, warp and core indices reach every term of every sum.

// File: rtl/csr_id_pkg.sv
package csr_id_pkg;
  localparam int CSR_AW = 12;
  typedef logic [CSR_AW-1:0] csr_addr_t;

  localparam csr_addr_t A_WTID  = 12'hCC0;
  localparam csr_addr_t A_LTID  = 12'hCC1;
  localparam csr_addr_t A_GTID  = 12'hCC2;
  localparam csr_addr_t A_LWID  = 12'hCC3;
  localparam csr_addr_t A_GWID  = 12'hCC4;
  localparam csr_addr_t A_CORE  = 12'hCC5;
  localparam csr_addr_t A_NTHR  = 12'hFC0;
  localparam csr_addr_t A_NWRP  = 12'hFC1;
  localparam csr_addr_t A_NCOR  = 12'hFC2;
  localparam csr_addr_t A_CYC   = 12'hC00;
  localparam csr_addr_t A_CYC_H = 12'hC80;
  localparam csr_addr_t A_RET   = 12'hC02;
  localparam csr_addr_t A_RET_H = 12'hC82;

  function automatic logic is_fixed(csr_addr_t a);
    case (a)
      A_WTID, A_LTID, A_GTID, A_LWID, A_GWID, A_CORE,
      A_NTHR, A_NWRP, A_NCOR, A_CYC, A_CYC_H, A_RET, A_RET_H: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/csr_id_calc.sv
module csr_id_calc #(
  parameter int XLEN        = 32,
  parameter int NUM_THREADS = 4,
  parameter int NUM_WARPS   = 8,
  parameter int TID_W       = 2,
  parameter int WID_W       = 3,
  parameter int CID_W       = 2
) (
  input  logic [TID_W-1:0] tid,
  input  logic [WID_W-1:0] wid,
  input  logic [CID_W-1:0] cid,
  output logic [XLEN-1:0]  warp_tid,
  output logic [XLEN-1:0]  core_tid,
  output logic [XLEN-1:0]  glob_tid,
  output logic [XLEN-1:0]  core_wid,
  output logic [XLEN-1:0]  glob_wid
);
  localparam logic [XLEN-1:0] NT_X   = XLEN'(NUM_THREADS);
  localparam logic [XLEN-1:0] NW_X   = XLEN'(NUM_WARPS);
  localparam logic [XLEN-1:0] TPC_X  = XLEN'(NUM_THREADS * NUM_WARPS);

  logic [XLEN-1:0] tid_x, wid_x, cid_x;

  always_comb begin
    tid_x    = XLEN'(tid);
    wid_x    = XLEN'(wid);
    cid_x    = XLEN'(cid);
    warp_tid = tid_x;
    core_tid = tid_x + wid_x * NT_X;
    glob_tid = core_tid + TPC_X * cid_x;
    core_wid = wid_x;
    glob_wid = wid_x + NW_X * cid_x;
  end
endmodule

// File: rtl/csr_perf_ctr.sv
module csr_perf_ctr #(
  parameter int             W   = 64,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= RST;
    else if (inc) q <= q + W'(1);
  end
endmodule

// File: rtl/csr_gen_file.sv
module csr_gen_file #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/csr_id_unit.sv
module csr_id_unit
  import csr_id_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          NUM_THREADS = 4,
  parameter int          NUM_WARPS   = 8,
  parameter int          NUM_CORES   = 4,
  parameter int          GEN_DEPTH   = 16,
  parameter logic [63:0] CTR_RST     = 64'd0,
  localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int WID_W  = (NUM_WARPS   > 1) ? $clog2(NUM_WARPS)   : 1,
  localparam int CID_W  = (NUM_CORES   > 1) ? $clog2(NUM_CORES)   : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CID_W-1:0] core_id,
  input  logic             retire,
  input  logic [11:0]      rd_addr,
  input  logic [TID_W-1:0] rd_tid,
  input  logic [WID_W-1:0] rd_wid,
  output logic [XLEN-1:0]  rd_data,
  input  logic             wr_en,
  input  logic [11:0]      wr_addr,
  input  logic [XLEN-1:0]  wr_data
);
  localparam int GEN_AW = (GEN_DEPTH > 1) ? $clog2(GEN_DEPTH) : 1;
  localparam int CTR_W  = 64;

  logic [XLEN-1:0]  warp_tid, core_tid, glob_tid, core_wid, glob_wid;
  logic [CTR_W-1:0] cyc_cnt, ret_cnt;
  logic [XLEN-1:0]  gen_rdata;
  logic             gen_we;

  csr_id_calc #(
    .XLEN(XLEN), .NUM_THREADS(NUM_THREADS), .NUM_WARPS(NUM_WARPS),
    .TID_W(TID_W), .WID_W(WID_W), .CID_W(CID_W)
  ) u_calc (
    .tid(rd_tid), .wid(rd_wid), .cid(core_id),
    .warp_tid(warp_tid), .core_tid(core_tid), .glob_tid(glob_tid),
    .core_wid(core_wid), .glob_wid(glob_wid)
  );

  csr_perf_ctr #(.W(CTR_W), .RST(CTR_RST)) u_cyc (
    .clk(clk), .rst_n(rst_n), .inc(1'b1), .q(cyc_cnt)
  );

  csr_perf_ctr #(.W(CTR_W), .RST(CTR_RST)) u_ret (
    .clk(clk), .rst_n(rst_n), .inc(retire), .q(ret_cnt)
  );

  assign gen_we = wr_en && !is_fixed(wr_addr);

  csr_gen_file #(.XLEN(XLEN), .DEPTH(GEN_DEPTH), .AW(GEN_AW)) u_gen (
    .clk(clk), .rst_n(rst_n), .we(gen_we),
    .waddr(wr_addr[GEN_AW-1:0]), .wdata(wr_data),
    .raddr(rd_addr[GEN_AW-1:0]), .rdata(gen_rdata)
  );

  always_comb begin
    case (rd_addr)
      A_WTID:  rd_data = warp_tid;
      A_LTID:  rd_data = core_tid;
      A_GTID:  rd_data = glob_tid;
      A_LWID:  rd_data = core_wid;
      A_GWID:  rd_data = glob_wid;
      A_CORE:  rd_data = XLEN'(core_id);
      A_NTHR:  rd_data = XLEN'(NUM_THREADS);
      A_NWRP:  rd_data = XLEN'(NUM_WARPS);
      A_NCOR:  rd_data = XLEN'(NUM_CORES);
      A_CYC:   rd_data = XLEN'(cyc_cnt[31:0]);
      A_CYC_H: rd_data = XLEN'(cyc_cnt[63:32]);
      A_RET:   rd_data = XLEN'(ret_cnt[31:0]);
      A_RET_H: rd_data = XLEN'(ret_cnt[63:32]);
      default: rd_data = gen_rdata;
    endcase
  end
endmodule

// File: rtl/csr_id_chk.sv
module csr_id_chk #(
  parameter int XLEN  = 32,
  parameter int TID_W = 2,
  parameter int WID_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retire,
  input logic [11:0]      rd_addr,
  input logic [TID_W-1:0] rd_tid,
  input logic [WID_W-1:0] rd_wid,
  input logic [XLEN-1:0]  rd_data,
  input logic [63:0]      cyc_cnt,
  input logic [63:0]      ret_cnt
);
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cyc_cnt == $past(cyc_cnt) + 64'd1); // R6

  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(retire)) |-> ret_cnt == $past(ret_cnt) + 64'd1); // R7

  AST_RETIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(retire)) |-> $stable(ret_cnt)); // R7

  AST_WARP_TID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 12'hCC0) |-> rd_data == XLEN'(rd_tid)); // R1

  AST_LOCAL_WID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 12'hCC3) |-> rd_data == XLEN'(rd_wid)); // R4

  AST_CYC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 12'hC80) |-> rd_data == cyc_cnt[63:32]); // R6
endmodule

bind csr_id_unit csr_id_chk #(.XLEN(XLEN), .TID_W(TID_W), .WID_W(WID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire(retire), .rd_addr(rd_addr),
  .rd_tid(rd_tid), .rd_wid(rd_wid), .rd_data(rd_data),
  .cyc_cnt(cyc_cnt), .ret_cnt(ret_cnt)
);

// File: tb/tb_csr_id_unit.sv
module tb_csr_id_unit;
  localparam int          PERIOD = 10;
  localparam int          NT = 4, NW = 8, NC = 4;
  localparam logic [63:0] CRST = 64'h0000_0001_FFFF_FF00;

  logic        clk = 0, rst_n = 0, retire = 0, wr_en = 0;
  logic [1:0]  core_id = 0, rd_tid = 0;
  logic [2:0]  rd_wid = 0;
  logic [11:0] rd_addr = 0, wr_addr = 0;
  logic [31:0] wr_data = 0, rd_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] cyc_m, ret_m;
  logic [31:0] gen_m [16];

  always #(PERIOD/2) clk = ~clk;

  csr_id_unit #(.NUM_THREADS(NT), .NUM_WARPS(NW), .NUM_CORES(NC), .CTR_RST(CRST)) dut (
    .clk(clk), .rst_n(rst_n), .core_id(core_id), .retire(retire),
    .rd_addr(rd_addr), .rd_tid(rd_tid), .rd_wid(rd_wid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic bit fixed_addr(logic [11:0] a);
    return a inside {12'hCC0, 12'hCC1, 12'hCC2, 12'hCC3, 12'hCC4, 12'hCC5,
                     12'hFC0, 12'hFC1, 12'hFC2, 12'hC00, 12'hC80, 12'hC02, 12'hC82};
  endfunction

  function automatic logic [31:0] expect_rd(logic [11:0] a);
    int t = rd_tid, w = rd_wid, c = core_id;
    case (a)
      12'hCC0: return t;
      12'hCC1: return t + w*NT;
      12'hCC2: return t + w*NT + NT*NW*c;
      12'hCC3: return w;
      12'hCC4: return w + NW*c;
      12'hCC5: return c;
      12'hFC0: return NT;
      12'hFC1: return NW;
      12'hFC2: return NC;
      12'hC00: return cyc_m[31:0];
      12'hC80: return cyc_m[63:32];
      12'hC02: return ret_m[31:0];
      12'hC82: return ret_m[63:32];
      default: return gen_m[a[3:0]];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_m <= CRST; ret_m <= CRST;
      for (int i = 0; i < 16; i++) gen_m[i] <= '0;
    end else begin
      cyc_m <= cyc_m + 1;
      if (retire) ret_m <= ret_m + 1;
      if (wr_en && !fixed_addr(wr_addr)) gen_m[wr_addr[3:0]] <= wr_data;
    end
  end

  task automatic check(string req, logic [31:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, rd_addr, rd_data, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, string req);
    rd_addr = a; #1;
    check(req, expect_rd(a));
  endtask

  function automatic string req_of(logic [11:0] a);
    case (a)
      12'hCC0: return "R1";
      12'hCC1: return "R2";
      12'hCC2: return "R3";
      12'hCC3, 12'hCC4: return "R4";
      12'hCC5, 12'hFC0, 12'hFC1, 12'hFC2: return "R5";
      12'hC00, 12'hC80: return "R6";
      12'hC02, 12'hC82: return "R7";
      default: return "R8";
    endcase
  endfunction

  localparam logic [11:0] FIX [13] = '{12'hCC0, 12'hCC1, 12'hCC2, 12'hCC3, 12'hCC4, 12'hCC5,
                                      12'hFC0, 12'hFC1, 12'hFC2, 12'hC00, 12'hC80, 12'hC02, 12'hC82};

  initial begin
    void'($urandom(32'h5EED_0042));
    // R10-style reset state folded into R6, R7, R8
    repeat (2) @(negedge clk);
    rd(12'hC00, "R6"); rd(12'hC80, "R6"); rd(12'hC02, "R7"); rd(12'h035, "R8");
    rst_n = 1;
    @(negedge clk);
    // R9: write a generic entry, then hit the fixed aliases of index 0 and 2
    wr_en = 1; wr_addr = 12'h010; wr_data = 32'hA5A5_0001;
    @(negedge clk);
    wr_addr = 12'hCC0; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_addr = 12'hC02; wr_data = 32'h1234_5678;
    @(negedge clk);
    wr_en = 0; rd_tid = 2'd3;
    rd(12'h010, "R9"); rd(12'h002, "R9"); rd(12'hCC0, "R9"); rd(12'hC02, "R9");
    // directed corners: top indices, top core
    rd_tid = 2'd3; rd_wid = 3'd7; core_id = 2'd3;
    rd(12'hCC1, "R2"); rd(12'hCC2, "R3"); rd(12'hCC4, "R4");
    rd(12'hCC5, "R5"); rd(12'hFC0, "R5"); rd(12'hFC1, "R5"); rd(12'hFC2, "R5");
    // random mix
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      rd_tid  = 2'($urandom); rd_wid = 3'($urandom); core_id = 2'($urandom);
      retire  = 1'($urandom);
      wr_en   = ($urandom % 3) == 0;
      wr_addr = ($urandom % 4 == 0) ? FIX[$urandom % 13] : {1'b0, 7'($urandom), 4'($urandom)};
      wr_data = $urandom;
      begin
        logic [11:0] a = ($urandom % 2) ? FIX[$urandom % 13]
                                        : {1'b0, 7'($urandom), 4'($urandom)};
        rd(a, req_of(a));
      end
    end
    @(negedge clk);
    retire = 0; wr_en = 0;
    rd(12'hC80, "R6"); rd(12'hC00, "R6"); rd(12'hC82, "R7");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule